// File: doc/BRIEF.md
# Multi-Rate Serial Data Rate Hunter

This block is the digital half of a multi-rate clock-recovery loop. It runs from the 14.140 MHz reference clock and measures how many pulses the divided recovered clock produces in a fixed window of reference cycles. It compares that count with the expected count for the rate being tried. It tells the analog loop which divide ratio to apply, and it reports whether the loop has locked and at which rate.

In auto mode the block walks a fixed list of six candidate rates in ascending code order. It stays on each candidate for a set number of measurement windows and then moves on, returning to the first entry after the last one. An exclusion input removes the 177 Mb/s entry from the walk, so that a 270 Mb/s ASI stream cannot lock there by mistake. In manual mode the loop is pinned to a single rate given on an input.

Lock uses two thresholds. Acquiring lock needs two back-to-back measurements within 1% of the target count. Once locked, the loop stays locked until a measurement falls more than 2% away. In auto mode the reported rate stays at the last rate that locked, including while the block searches again.

Top module: `rate_hunt_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `locked` and `sd_flag`, clears the remembered rate to 000 and sets the auto search candidate to 000.
- R2: Rate codes: 000 = 143, 001 = 177, 010 = 270, 011 = 360, 100 = 540 and 101 = 1483.5/1485 Mb/s. Each code has its own expected pulse count per window, set by `TGT_COUNT`. The defaults are 200, 250, 300, 350, 400 and 450 pulses in `WIN_LEN` = 1000 reference cycles.
- R3: In auto mode (`auto_en` = 1) and while unlocked, `div_sel` steps through 000, 001, 010, 011, 100, 101 and then wraps to 000.
- R4: In auto mode, a candidate that sees no in-tolerance measurement is held for exactly `DWELL_WINS`×`WIN_LEN`+2 reference cycles between changes of `div_sel`.
- R5: While `skip_177` is high, the auto search never selects code 001. It goes from 000 straight to 010.
- R6: Lock is declared after two consecutive windows whose count C meets |C−T| ≤ T/100 (integer division), where T is the target of the selected code. After the edge that restarts measurement, `locked` rises at edge 2×`WIN_LEN`+1.
- R7: While locked, a window with |C−T| ≤ 2T/100 keeps lock. A window outside that range clears `locked`.
- R8: An unlocked loop never locks on counts with T/100 < |C−T| ≤ 2T/100.
- R9: In auto mode, `rate_code` shows the code of the most recent lock and keeps it after lock is lost and while the search continues.
- R10: In manual mode (`auto_en` = 0), `div_sel` and `rate_code` equal `forced_rate`, and do not change while `forced_rate` is held. The unused codes 110 and 111 select 101.
- R11: `sd_flag` is high only while locked to a code from 000 to 100. It is low when locked to 101 and whenever unlocked.
- R12: A change of the selected rate (for example a new `forced_rate`) clears `locked` at the next edge and restarts measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (14.140 MHz crystal domain) |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_en | input | 1 | 1 = search candidate rates, 0 = use `forced_rate` |
| forced_rate | input | 3 | Rate code applied in manual mode |
| skip_177 | input | 1 | Removes code 001 from the auto search |
| vco_tick | input | 1 | One-cycle pulse from the divided recovered clock |
| div_sel | output | 3 | Rate code that selects the recovered-clock divider |
| rate_code | output | 3 | Reported rate: last locked rate (auto) or forced rate (manual) |
| locked | output | 1 | High while the loop is locked |
| sd_flag | output | 1 | High while locked to a standard-definition rate |

## Verification
The assertions assume that `auto_en` and `skip_177` change only between clock edges. They also assume that `vco_tick` is a single-cycle pulse synchronous to the reference clock, and that reset is held for at least one edge before the checked behaviour starts. The bench drives every input on the falling edge. It makes `vco_tick` with a phase accumulator, which puts exactly N pulses in any run of `WIN_LEN` consecutive cycles. As a result, every full window measures a count the bench knows. The only exception is the window in which N is changed, and the bench does no checks there.

// File: rtl/rate_hunt_pkg.sv
// Package: shared constants and helpers for the rate hunter.
// Assumes six candidate rates coded 0..5, with code 5 the HD rate.
package rate_hunt_pkg;

    localparam int unsigned NUM_RATES = 6;
    localparam int unsigned RATE_W    = 3;
    localparam logic [2:0]  CODE_177  = 3'd1;
    localparam logic [2:0]  CODE_HD   = 3'd5;
    localparam logic [2:0]  CODE_LAST = 3'd5;

    // Next candidate in the ascending search, wrapping after the last code.
    function automatic logic [2:0] next_rate(input logic [2:0] cur, input logic skip);
        logic [2:0] nxt;
        if (cur >= CODE_LAST) nxt = 3'd0;
        else                  nxt = cur + 3'd1;
        if (skip && nxt == CODE_177) nxt = CODE_177 + 3'd1;
        return nxt;
    endfunction

    // Maps unused codes onto the highest valid code.
    function automatic logic [2:0] clamp_code(input logic [2:0] code);
        return (code > CODE_LAST) ? CODE_LAST : code;
    endfunction

endpackage

// File: rtl/win_meter.sv
// Window meter: counts vco_tick pulses over WIN_LEN reference cycles.
// restart clears the window and drops any pending result. done is a
// one-cycle pulse carrying the count of the window that just closed.
module win_meter #(
    parameter int unsigned WIN_LEN = 1000,
    localparam int unsigned CW     = $clog2(WIN_LEN + 1),
    localparam int unsigned PW     = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    output logic          done,
    output logic [CW-1:0] count
);

    localparam logic [PW-1:0] LAST_POS = PW'(WIN_LEN - 1);

    logic [PW-1:0] pos_q;
    logic [CW-1:0] acc_q;

    // Window position, tick accumulation and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos_q <= '0;
            acc_q <= '0;
            done  <= 1'b0;
            count <= '0;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
            acc_q <= '0;
            done  <= 1'b1;
            count <= acc_q + CW'(tick);
        end else begin
            pos_q <= pos_q + 1'b1;
            acc_q <= acc_q + CW'(tick);
            done  <= 1'b0;
        end
    end

endmodule

// File: rtl/tol_judge.sv
// Tolerance judge: compares a window count with the target of the
// selected rate. Tight band = 1% (acquire), wide band = 2% (hold).
// Bounds are computed per rate at elaboration time.
module tol_judge #(
    parameter int unsigned CW = 10,
    parameter int unsigned TGT_COUNT [rate_hunt_pkg::NUM_RATES] = '{200, 250, 300, 350, 400, 450}
) (
    input  logic [2:0]    sel,
    input  logic [CW-1:0] count,
    output logic          in_tight,
    output logic          in_wide
);
    import rate_hunt_pkg::*;

    logic [NUM_RATES-1:0] tight_v;
    logic [NUM_RATES-1:0] wide_v;
    logic [31:0]          cnt32;

    // Width-extend the count once for all comparisons.
    always_comb cnt32 = 32'(count);

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_band
        localparam int unsigned T   = TGT_COUNT[r];
        localparam int unsigned D1  = T / 100;
        localparam int unsigned D2  = (2 * T) / 100;
        localparam logic [31:0] LO1 = 32'(T - D1);
        localparam logic [31:0] HI1 = 32'(T + D1);
        localparam logic [31:0] LO2 = 32'(T - D2);
        localparam logic [31:0] HI2 = 32'(T + D2);
        // Band membership of this rate's target.
        always_comb begin
            tight_v[r] = (cnt32 >= LO1) && (cnt32 <= HI1);
            wide_v[r]  = (cnt32 >= LO2) && (cnt32 <= HI2);
        end
    end

    // Select the verdict for the rate being tried.
    always_comb begin
        in_tight = 1'b0;
        in_wide  = 1'b0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (sel == 3'(i)) begin
                in_tight = tight_v[i];
                in_wide  = wide_v[i];
            end
        end
    end

endmodule

// File: rtl/lock_keeper.sv
// Lock keeper: search index, dwell counting, two-hit acquisition,
// wide-band hold, remembered rate and SD flag. Acts only on measurement
// results; a restart wipes the lock and the pending hit.
module lock_keeper #(
    parameter int unsigned DWELL_WINS = 3,
    localparam int unsigned DW        = (DWELL_WINS > 1) ? $clog2(DWELL_WINS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic       skip_177,
    input  logic       restart,
    input  logic       meas_done,
    input  logic       in_tight,
    input  logic       in_wide,
    input  logic [2:0] sel,
    output logic [2:0] hunt_idx,
    output logic [2:0] last_rate,
    output logic       locked,
    output logic       sd_flag
);
    import rate_hunt_pkg::*;

    localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL_WINS - 1);

    logic          hit_q;
    logic [DW-1:0] dwell_q;

    // Lock state machine and search stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunt_idx  <= 3'd0;
            last_rate <= 3'd0;
            locked    <= 1'b0;
            sd_flag   <= 1'b0;
            hit_q     <= 1'b0;
            dwell_q   <= '0;
        end else if (restart) begin
            locked  <= 1'b0;
            sd_flag <= 1'b0;
            hit_q   <= 1'b0;
            dwell_q <= '0;
        end else if (meas_done) begin
            if (locked) begin
                if (!in_wide) begin
                    locked  <= 1'b0;
                    sd_flag <= 1'b0;
                    hit_q   <= 1'b0;
                    dwell_q <= '0;
                end
            end else if (in_tight) begin
                if (hit_q) begin
                    locked    <= 1'b1;
                    sd_flag   <= (sel != CODE_HD);
                    last_rate <= sel;
                    hit_q     <= 1'b0;
                end else begin
                    hit_q <= 1'b1;
                end
            end else begin
                hit_q <= 1'b0;
                if (auto_en) begin
                    if (dwell_q == DWELL_LAST) begin
                        dwell_q  <= '0;
                        hunt_idx <= next_rate(hunt_idx, skip_177);
                    end else begin
                        dwell_q <= dwell_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rate_hunt_ctrl.sv
// Rate hunter top: picks the candidate rate (search or forced), restarts
// measurement whenever the selection changes, and wires meter, judge and
// lock keeper. Assumes vco_tick is a single-cycle pulse in the clk domain.
module rate_hunt_ctrl #(
    parameter int unsigned WIN_LEN    = 1000,
    parameter int unsigned DWELL_WINS = 3,
    parameter int unsigned TGT_COUNT [rate_hunt_pkg::NUM_RATES] = '{200, 250, 300, 350, 400, 450},
    localparam int unsigned CW        = $clog2(WIN_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic [2:0] forced_rate,
    input  logic       skip_177,
    input  logic       vco_tick,
    output logic [2:0] div_sel,
    output logic [2:0] rate_code,
    output logic       locked,
    output logic       sd_flag
);
    import rate_hunt_pkg::*;

    logic [2:0]    hunt_idx;
    logic [2:0]    last_rate;
    logic [2:0]    forced_c;
    logic [2:0]    sel_q;
    logic          restart;
    logic          meas_done;
    logic [CW-1:0] meas_count;
    logic          in_tight;
    logic          in_wide;

    // Candidate and reported-rate selection.
    always_comb begin
        forced_c  = clamp_code(forced_rate);
        div_sel   = auto_en ? hunt_idx  : forced_c;
        rate_code = auto_en ? last_rate : forced_c;
        restart   = (div_sel != sel_q);
    end

    // Remember the selection seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 3'd0;
        else        sel_q <= div_sel;
    end

    win_meter #(.WIN_LEN(WIN_LEN)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (vco_tick),
        .done    (meas_done),
        .count   (meas_count)
    );

    tol_judge #(.CW(CW), .TGT_COUNT(TGT_COUNT)) u_judge (
        .sel      (div_sel),
        .count    (meas_count),
        .in_tight (in_tight),
        .in_wide  (in_wide)
    );

    lock_keeper #(.DWELL_WINS(DWELL_WINS)) u_keeper (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_en),
        .skip_177  (skip_177),
        .restart   (restart),
        .meas_done (meas_done),
        .in_tight  (in_tight),
        .in_wide   (in_wide),
        .sel       (div_sel),
        .hunt_idx  (hunt_idx),
        .last_rate (last_rate),
        .locked    (locked),
        .sd_flag   (sd_flag)
    );

endmodule

// File: rtl/rate_hunt_ctrl_chk.sv
// Checker for the rate hunter, bound to the top. It sees ports only and
// assumes inputs change between clock edges.
module rate_hunt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_en,
    input logic       skip_177,
    input logic [2:0] div_sel,
    input logic [2:0] rate_code,
    input logic       locked,
    input logic       sd_flag
);
    import rate_hunt_pkg::*;

    // First edge after reset: no lock, no SD flag.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!locked && !sd_flag));

    // Auto search moves only to the next allowed code.
    assert_search_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_en && $past(auto_en) && div_sel != $past(div_sel))
        |-> div_sel == next_rate($past(div_sel), $past(skip_177)));

    // Excluded code is never entered by the search.
    assert_skip_177_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_en && $past(auto_en) && $past(skip_177) && div_sel != $past(div_sel))
        |-> div_sel != CODE_177);

    // A held lock in auto mode keeps the divider selection.
    assert_lock_holds_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_en && $past(auto_en) && locked && $past(locked))
        |-> $stable(div_sel));

    // On acquiring lock in auto mode, the reported rate is the tried rate.
    assert_lock_records_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && auto_en && $past(auto_en) && $rose(locked)) |-> rate_code == div_sel);

    // SD flag follows the locked rate class.
    assert_sd_class_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && auto_en && $past(auto_en) && $past(rst_n)) |-> (sd_flag == (rate_code != CODE_HD)));

    // SD flag never shows without lock.
    assert_sd_needs_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sd_flag |-> locked);

endmodule

bind rate_hunt_ctrl rate_hunt_ctrl_chk u_rate_hunt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_en   (auto_en),
    .skip_177  (skip_177),
    .div_sel   (div_sel),
    .rate_code (rate_code),
    .locked    (locked),
    .sd_flag   (sd_flag)
);

// File: tb/test_rate_hunt_ctrl.sv
// Directed bench for the rate hunter: one task per scenario.
module test_rate_hunt_ctrl;

    localparam int unsigned W     = 1000;
    localparam int unsigned DWELL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_en = 1'b1;
    logic [2:0] forced_rate = 3'd0;
    logic       skip_177 = 1'b0;
    logic       vco_tick = 1'b0;
    logic [2:0] div_sel;
    logic [2:0] rate_code;
    logic       locked;
    logic       sd_flag;

    int n_pulses = 0;
    int compared = 0;
    int mismatched = 0;
    longint cyc = 0;
    int chg_cnt = 0;
    int chg_val [32];
    longint chg_t [32];
    logic [2:0] last_sel = 3'd0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    rate_hunt_ctrl #(.WIN_LEN(W), .DWELL_WINS(DWELL)) i_rate_hunt_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .forced_rate(forced_rate),
        .skip_177(skip_177), .vco_tick(vco_tick), .div_sel(div_sel),
        .rate_code(rate_code), .locked(locked), .sd_flag(sd_flag)
    );

    // Pulse source: exactly n_pulses ticks in any W consecutive cycles.
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            phase = phase + n_pulses;
            if (phase >= int'(W)) begin
                phase = phase - int'(W);
                vco_tick = 1'b1;
            end else begin
                vco_tick = 1'b0;
            end
        end
    end

    // Log of divider selection changes with the negedge cycle number.
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            if (div_sel !== last_sel) begin
                if (chg_cnt < 32) begin
                    chg_val[chg_cnt] = int'(div_sel);
                    chg_t[chg_cnt]   = cyc;
                end
                chg_cnt  = chg_cnt + 1;
                last_sel = div_sel;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        chg_cnt  = 0;
        last_sel = div_sel;
    endtask

    task automatic do_reset(input logic mode, input logic skip, input int n);
        @(negedge clk);
        rst_n = 1'b0; auto_en = mode; skip_177 = skip; n_pulses = n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clear_log();
    endtask

    task automatic wait_lock(input int max_cyc, output bit got);
        got = 0;
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk);
            if (locked) begin got = 1; break; end
        end
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        do_reset(1'b1, 1'b0, 0);
        chk("R1", "locked", int'(locked), 0);
        chk("R1", "sd_flag", int'(sd_flag), 0);
        chk("R1", "rate_code", int'(rate_code), 0);
        chk("R1", "div_sel", int'(div_sel), 0);
    endtask

    // R3/R4: unlocked search order, wrap and dwell interval.
    task automatic t_search_order();
        do_reset(1'b1, 1'b0, 0);
        repeat (19000) @(negedge clk);
        chk("R3", "change count", (chg_cnt >= 6) ? 1 : 0, 1);
        for (int k = 0; k < 6; k++)
            chk("R3", "order", chg_val[k], (k + 1) % 6);
        chk("R4", "dwell cycles", int'(chg_t[2] - chg_t[1]), int'(DWELL * W + 2));
        chk("R4", "dwell cycles wrap", int'(chg_t[5] - chg_t[4]), int'(DWELL * W + 2));
    endtask

    // R5: exclusion of code 001.
    task automatic t_skip();
        do_reset(1'b1, 1'b1, 0);
        repeat (16000) @(negedge clk);
        chk("R5", "change count", (chg_cnt >= 5) ? 1 : 0, 1);
        chk("R5", "first step", chg_val[0], 2);
        chk("R5", "wrap to 0", chg_val[3], 5);
        chk("R5", "after wrap", chg_val[4], 0);
    endtask

    // R6/R7/R8/R9/R11: auto lock at 270, hysteresis, drop and memory; R1 again.
    task automatic t_auto_lock_sd();
        bit got;
        do_reset(1'b1, 1'b0, 300);
        wait_lock(12000, got);
        chk("R6", "lock reached", int'(got), 1);
        chk("R9", "rate_code", int'(rate_code), 2);
        chk("R2", "div_sel", int'(div_sel), 2);
        chk("R11", "sd_flag SD", int'(sd_flag), 1);
        n_pulses = 305;                 // within 2%, outside 1%
        repeat (5 * W) @(negedge clk);
        chk("R7", "held at +1.7%", int'(locked), 1);
        n_pulses = 320;                 // beyond 2%
        repeat (3 * W) @(negedge clk);
        chk("R7", "dropped at +6.7%", int'(locked), 0);
        chk("R11", "sd_flag unlocked", int'(sd_flag), 0);
        chk("R9", "rate kept", int'(rate_code), 2);
        n_pulses = 305;
        clear_log();
        got = 0;
        for (int i = 0; i < 20 * int'(W); i++) begin
            @(negedge clk);
            if (locked) got = 1;
        end
        chk("R8", "no lock in 1..2% band", int'(got), 0);
        chk("R9", "rate kept while searching", int'(rate_code), 2);
        chk("R3", "search resumed", (chg_cnt > 0) ? 1 : 0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "memory cleared", int'(rate_code), 0);
        chk("R1", "lock cleared", int'(locked), 0);
    endtask

    // R11: lock at the HD rate keeps sd_flag low.
    task automatic t_hd();
        bit got;
        do_reset(1'b1, 1'b0, 450);
        wait_lock(20000, got);
        chk("R2", "HD lock reached", int'(got), 1);
        chk("R9", "HD rate_code", int'(rate_code), 5);
        chk("R11", "sd_flag HD", int'(sd_flag), 0);
    endtask

    // R6/R10/R12: manual forcing, exact acquisition timing, rate change.
    task automatic t_manual();
        do_reset(1'b0, 1'b0, 200);
        forced_rate = 3'd5;
        repeat (3 * W) @(negedge clk);
        chk("R10", "forced div_sel", int'(div_sel), 5);
        chk("R10", "forced rate_code", int'(rate_code), 5);
        chk("R10", "no lock on wrong rate", int'(locked), 0);
        forced_rate = 3'd0;             // restart edge follows
        repeat (2 * W + 1) @(posedge clk);
        @(negedge clk);
        chk("R6", "not yet locked at 2W", int'(locked), 0);
        @(negedge clk);
        chk("R6", "locked at 2W+1", int'(locked), 1);
        chk("R11", "sd_flag manual", int'(sd_flag), 1);
        clear_log();
        repeat (4 * W) @(negedge clk);
        chk("R10", "div_sel held", chg_cnt, 0);
        chk("R7", "stays locked", int'(locked), 1);
        forced_rate = 3'd2;
        @(negedge clk);
        chk("R12", "lock cleared on change", int'(locked), 0);
        chk("R10", "new div_sel", int'(div_sel), 2);
        forced_rate = 3'd7;
        @(negedge clk);
        chk("R10", "code 7 clamps", int'(div_sel), 5);
        chk("R10", "code 7 reported", int'(rate_code), 5);
    endtask

    initial begin
        t_reset();
        t_search_order();
        t_skip();
        t_auto_lock_sd();
        t_hd();
        t_manual();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule